// File: doc/BRIEF.md
# Key-Protected Register Access Lock Gate

This block sits in front of a bank of 64-bit model-specific registers and decides, for each request, whether the access may proceed. It keeps a one-bit lock flag in its own lock register. That register can always be reached. Writing one exact 64-bit key to it clears the flag, and writing any other value sets it. While the flag is set, unprivileged instruction-path accesses to addresses above the protected base are refused with a protection-fault pulse. Requests from the internal bus, and requests made in either privileged mode (system-management or debug-management), pass regardless of the flag.

Each accepted request leaves on one of two outputs. Low addresses go to the local register strobe. Addresses above the bus base become an outbound bus transaction, except while locked, when that transaction is suppressed. Every request produces exactly one registered outcome, one cycle after it is presented. The possible outcomes are a local strobe, a bus strobe, or a response from the gate itself. A gate response covers lock-register accesses, faults and suppressed bus accesses.

Top module: `msr_lock_gate`

## Requirements
- R1: After synchronous active-low reset the lock flag is 0 (unlocked) and every output is 0.
- R2: A write to the lock address with data 64'h4552_4F43_4C49_4156 clears the lock flag. A write there with any other data, including one differing in a single bit, sets it.
- R3: A read of the lock address gives resp_valid with resp_rdata bit 0 equal to the lock flag and bits 63:1 zero. A lock-address access is never faulted and never forwarded.
- R4: While locked, an instruction-path request (req_from_bus=0) with both privilege inputs 0, to an address above 0xFFF other than the lock address, gives fault=1 and resp_valid=1 with resp_rdata=0. It gives no local or bus strobe, so a blocked write reaches no register.
- R5: A request with req_from_bus=1, or with priv_sys=1 or priv_dbg=1, is never faulted, whatever the lock state.
- R6: A request to an address at or below 0xFFF is never faulted, whatever the lock state.
- R7: An allowed request to an address above 0x3FFF gives bus_valid while unlocked. While locked it gives no bus strobe, no local strobe and no fault, but resp_valid with resp_rdata=0.
- R8: An allowed request to an address at or below 0x3FFF, other than the lock address, gives fwd_valid. out_write, out_addr and out_wdata equal the request's values.
- R9: All outputs are registered and appear in the cycle after the request. A lock write changes the judgement of requests from the next cycle on. It does not change the judgement of the request that carries the write itself.
- R10: Each request yields exactly one of fwd_valid, bus_valid or resp_valid for one cycle, and none appears without a request. out_write, out_addr and out_wdata are 0 when neither strobe is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_from_bus | input | 1 | 1 = internal bus requester, 0 = instruction path |
| priv_sys | input | 1 | Requester in system-management mode |
| priv_dbg | input | 1 | Requester in debug-management mode |
| req_addr | input | 32 | Register address |
| req_wdata | input | 64 | Write data |
| fwd_valid | output | 1 | One-cycle strobe to the local register bank |
| bus_valid | output | 1 | One-cycle outbound bus transaction strobe |
| out_write | output | 1 | Write flag of the forwarded access |
| out_addr | output | 32 | Address of the forwarded access |
| out_wdata | output | 64 | Data of the forwarded access |
| resp_valid | output | 1 | Gate-local response (lock register, fault or suppressed bus access) |
| resp_rdata | output | 64 | Gate-local read data |
| fault | output | 1 | One-cycle protection-fault pulse |

## Verification
The lock flag is the only internal state. Its value can be seen at the ports one cycle after any lock-register read. A flag that is wrong is also visible in the next request's outcome. A protected unprivileged access shows a fault where a strobe was due, or the reverse. A high-address access shows a bus strobe where a silent response was due. The bench interleaves lock writes, near-miss keys and read-backs with requests of every requester class and address region, so a wrong flag shows within one or two cycles of the bad update.

// File: rtl/msr_gate_pkg.sv
// Shared types for the register access lock gate.
// Assumes: nothing beyond IEEE 1800-2017.
package msr_gate_pkg;

    // Outcome chosen for one request.
    typedef enum logic [2:0] {
        ROUTE_NONE    = 3'd0,
        ROUTE_LOCAL   = 3'd1,
        ROUTE_BUS     = 3'd2,
        ROUTE_LOCKREG = 3'd3,
        ROUTE_FAULT   = 3'd4,
        ROUTE_DROP    = 3'd5
    } route_e;

endpackage

// File: rtl/msr_lock_flag.sv
// Lock flag register: holds the one-bit lock state.
// A write clears the flag on an exact key match and sets it otherwise.
// Assumes: wr_en is asserted for at most one cycle per lock write request.
module msr_lock_flag #(
    parameter int                DATA_W     = 64,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 64'h4552_4F43_4C49_4156
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              locked
);

    logic key_hit;

    // Exact comparison of the written word against the unlock key.
    always_comb begin
        key_hit = (wr_data == UNLOCK_KEY);
    end

    // Flag update: reset unlocked, then follow each lock write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
        end else if (wr_en) begin
            locked <= !key_hit;
        end
    end

    // R2
    key_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == UNLOCK_KEY) |=> !locked);

    // R2
    other_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data != UNLOCK_KEY) |=> locked);

    // R9
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(locked));

endmodule

// File: rtl/msr_access_judge.sv
// Access judge: classifies one request into a route from the requester
// class, the privilege indications, the address region and the lock flag.
// Purely combinational. Assumes LOCK_ADDR lies above PROT_BASE.
module msr_access_judge
    import msr_gate_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 32'h0000_1908,
    parameter logic [ADDR_W-1:0] PROT_BASE = 32'h0000_0FFF,
    parameter logic [ADDR_W-1:0] BUS_BASE  = 32'h0000_3FFF
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_from_bus,
    input  logic              priv_sys,
    input  logic              priv_dbg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              locked,
    output route_e            route,
    output logic              lock_wr
);

    logic is_lock_addr;
    logic exempt;
    logic in_prot;
    logic in_bus;

    // Address region and requester class decode.
    always_comb begin
        is_lock_addr = (req_addr == LOCK_ADDR);
        exempt       = req_from_bus || priv_sys || priv_dbg;
        in_prot      = (req_addr > PROT_BASE);
        in_bus       = (req_addr > BUS_BASE);
    end

    // Route selection in priority order: lock register, fault, bus region, local.
    always_comb begin
        route = ROUTE_NONE;
        if (req_valid) begin
            if (is_lock_addr) begin
                route = ROUTE_LOCKREG;
            end else if (locked && !exempt && in_prot) begin
                route = ROUTE_FAULT;
            end else if (in_bus) begin
                route = locked ? ROUTE_DROP : ROUTE_BUS;
            end else begin
                route = ROUTE_LOCAL;
            end
        end
    end

    // Lock register write strobe, always permitted.
    always_comb begin
        lock_wr = req_valid && req_write && is_lock_addr;
    end

endmodule

// File: rtl/msr_gate_outputs.sv
// Output stage: registers the outcome of each routed request into the
// forward strobes, the gate-local response and the fault pulse.
// Assumes: route and the request fields belong to the same cycle.
module msr_gate_outputs
    import msr_gate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  route_e            route,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              locked,
    output logic              fwd_valid,
    output logic              bus_valid,
    output logic              out_write,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              fault
);

    localparam logic [DATA_W-1:0] ZERO_WORD = '0;

    logic passes;

    // A request is passed on when it goes to the local bank or the bus.
    always_comb begin
        passes = (route == ROUTE_LOCAL) || (route == ROUTE_BUS);
    end

    // Forward strobes and pass-through of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            bus_valid <= 1'b0;
            out_write <= 1'b0;
            out_addr  <= '0;
            out_wdata <= '0;
        end else begin
            fwd_valid <= (route == ROUTE_LOCAL);
            bus_valid <= (route == ROUTE_BUS);
            out_write <= passes ? req_write : 1'b0;
            out_addr  <= passes ? req_addr  : '0;
            out_wdata <= passes ? req_wdata : ZERO_WORD;
        end
    end

    // Gate-local response and fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_rdata <= '0;
            fault      <= 1'b0;
        end else begin
            resp_valid <= (route == ROUTE_LOCKREG) || (route == ROUTE_FAULT)
                          || (route == ROUTE_DROP);
            resp_rdata <= ZERO_WORD;
            if (route == ROUTE_LOCKREG && !req_write) begin
                resp_rdata <= {{(DATA_W-1){1'b0}}, locked};
            end
            fault      <= (route == ROUTE_FAULT);
        end
    end

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_valid, bus_valid, resp_valid}));

    // R9
    outcome_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid || bus_valid || resp_valid) |-> $past(req_valid));

    // R4
    fault_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (resp_valid && resp_rdata == ZERO_WORD && !fwd_valid && !bus_valid));

    // R7
    bus_only_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !$past(locked));

    // R8
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (out_addr == $past(req_addr) && out_wdata == $past(req_wdata)));

endmodule

// File: rtl/msr_lock_gate.sv
// Register access lock gate, top level.
// Judges each request against the lock flag and emits one registered
// outcome per request. Assumes at most one request per cycle.
module msr_lock_gate
    import msr_gate_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 64,
    parameter logic [ADDR_W-1:0] LOCK_ADDR  = 32'h0000_1908,
    parameter logic [ADDR_W-1:0] PROT_BASE  = 32'h0000_0FFF,
    parameter logic [ADDR_W-1:0] BUS_BASE   = 32'h0000_3FFF,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 64'h4552_4F43_4C49_4156
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_from_bus,
    input  logic              priv_sys,
    input  logic              priv_dbg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              fwd_valid,
    output logic              bus_valid,
    output logic              out_write,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              fault
);

    route_e route;
    logic   lock_wr;
    logic   locked;

    msr_lock_flag #(
        .DATA_W     (DATA_W),
        .UNLOCK_KEY (UNLOCK_KEY)
    ) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lock_wr),
        .wr_data (req_wdata),
        .locked  (locked)
    );

    msr_access_judge #(
        .ADDR_W    (ADDR_W),
        .LOCK_ADDR (LOCK_ADDR),
        .PROT_BASE (PROT_BASE),
        .BUS_BASE  (BUS_BASE)
    ) u_judge (
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_from_bus (req_from_bus),
        .priv_sys     (priv_sys),
        .priv_dbg     (priv_dbg),
        .req_addr     (req_addr),
        .locked       (locked),
        .route        (route),
        .lock_wr      (lock_wr)
    );

    msr_gate_outputs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .route      (route),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .locked     (locked),
        .fwd_valid  (fwd_valid),
        .bus_valid  (bus_valid),
        .out_write  (out_write),
        .out_addr   (out_addr),
        .out_wdata  (out_wdata),
        .resp_valid (resp_valid),
        .resp_rdata (resp_rdata),
        .fault      (fault)
    );

    // R5
    exempt_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_from_bus || priv_sys || priv_dbg)) |=> !fault);

    // R6
    low_addr_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr <= PROT_BASE) |=> !fault);

    // R3
    lock_addr_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == LOCK_ADDR) |=> (resp_valid && !fault));

endmodule

// File: tb/tb_msr_lock_gate.sv
// Bench for the lock gate: a behavioural model predicts every output for
// each request, and the outputs are compared on every clock.
module tb_msr_lock_gate;

    localparam logic [63:0] KEY   = 64'h4552_4F43_4C49_4156;
    localparam logic [31:0] LADDR = 32'h0000_1908;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_from_bus = 1'b0;
    logic        priv_sys = 1'b0, priv_dbg = 1'b0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        fwd_valid, bus_valid, out_write, resp_valid, fault;
    logic [31:0] out_addr;
    logic [63:0] out_wdata, resp_rdata;

    int compared = 0;
    int mismatched = 0;

    // Model state and expectations.
    bit          m_locked = 1'b0;
    bit          p_lockwr = 1'b0;
    logic [63:0] p_data = '0;
    string       p_tag = "R1";
    logic        e_fwd = 0, e_bus = 0, e_wr = 0, e_resp = 0, e_fault = 0;
    logic [31:0] e_addr = '0;
    logic [63:0] e_wdata = '0, e_rdata = '0;

    always #4 clk = ~clk;

    msr_lock_gate dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_from_bus(req_from_bus), .priv_sys(priv_sys), .priv_dbg(priv_dbg),
        .req_addr(req_addr), .req_wdata(req_wdata), .fwd_valid(fwd_valid),
        .bus_valid(bus_valid), .out_write(out_write), .out_addr(out_addr),
        .out_wdata(out_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .fault(fault)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(p_tag, "fwd_valid",  64'(fwd_valid),  64'(e_fwd));
        chk(p_tag, "bus_valid",  64'(bus_valid),  64'(e_bus));
        chk(p_tag, "out_write",  64'(out_write),  64'(e_wr));
        chk(p_tag, "out_addr",   64'(out_addr),   64'(e_addr));
        chk(p_tag, "out_wdata",  out_wdata,       e_wdata);
        chk(p_tag, "resp_valid", 64'(resp_valid), 64'(e_resp));
        chk(p_tag, "resp_rdata", resp_rdata,      e_rdata);
        chk(p_tag, "fault",      64'(fault),      64'(e_fault));
    endtask

    // One cycle: check previous outcome, advance model, apply a new request.
    task automatic step(input string tag, input bit v, input bit w, input bit fb,
                        input bit ps, input bit pd, input logic [31:0] a,
                        input logic [63:0] d);
        bit exempt;
        @(negedge clk);
        compare_all();
        if (p_lockwr) m_locked = (p_data != KEY);
        req_valid = v; req_write = w; req_from_bus = fb;
        priv_sys = ps; priv_dbg = pd; req_addr = a; req_wdata = d;
        e_fwd = 0; e_bus = 0; e_wr = 0; e_addr = '0; e_wdata = '0;
        e_resp = 0; e_rdata = '0; e_fault = 0;
        exempt = fb || ps || pd;
        p_lockwr = v && w && (a == LADDR);
        p_data = d;
        p_tag = tag;
        if (v) begin
            if (a == LADDR) begin
                e_resp = 1;
                if (!w) e_rdata = {63'd0, m_locked};
            end else if (m_locked && !exempt && a > 32'h0FFF) begin
                e_resp = 1; e_fault = 1;
            end else if (a > 32'h3FFF) begin
                if (m_locked) e_resp = 1;
                else begin e_bus = 1; e_wr = w; e_addr = a; e_wdata = d; end
            end else begin
                e_fwd = 1; e_wr = w; e_addr = a; e_wdata = d;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset outputs, then R3 read of unlocked flag
        step("R1", 0, 0, 0, 0, 0, '0, '0);
        step("R3", 1, 0, 0, 0, 0, LADDR, '0);
        // R8 unlocked local accesses, pass-through
        step("R8", 1, 1, 0, 0, 0, 32'h1000, 64'hDEAD_BEEF_0123_4567);
        step("R8", 1, 0, 0, 0, 0, 32'h3FFF, 64'h0);
        // R7 unlocked bus access
        step("R7", 1, 1, 0, 0, 0, 32'h4000, 64'h1111_2222_3333_4444);
        // R2 lock by writing zero; R9 same-cycle request judged old
        step("R2", 1, 1, 0, 0, 0, LADDR, 64'h0);
        step("R3", 1, 0, 0, 0, 0, LADDR, '0);
        // R4 blocked write and read
        step("R4", 1, 1, 0, 0, 0, 32'h1500, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R4", 1, 0, 0, 0, 0, 32'h1000, '0);
        // R6 boundary below protected base
        step("R6", 1, 1, 0, 0, 0, 32'h0FFF, 64'h55);
        // R5 exempt requesters
        step("R5", 1, 1, 1, 0, 0, 32'h1500, 64'hA5);
        step("R5", 1, 0, 0, 1, 0, 32'h2000, 64'h0);
        step("R5", 1, 1, 0, 0, 1, 32'h3000, 64'h77);
        // R7 suppressed bus access while locked
        step("R7", 1, 1, 1, 0, 0, 32'h8000, 64'h99);
        step("R7", 1, 0, 0, 1, 0, 32'h4000, 64'h0);
        // R2 unlock with key, R9 next cycle judged unlocked
        step("R2", 1, 1, 0, 0, 0, LADDR, KEY);
        step("R9", 1, 1, 0, 0, 0, 32'h1500, 64'h42);
        step("R3", 1, 0, 0, 0, 0, LADDR, '0);
        // R2 near-miss key locks
        step("R2", 1, 1, 0, 0, 0, LADDR, KEY ^ 64'h1);
        step("R9", 1, 0, 0, 0, 0, 32'h1500, '0);
        step("R2", 1, 1, 1, 0, 0, LADDR, KEY);
        step("R10", 0, 1, 0, 0, 0, 32'h1500, 64'h5);
        // Mixed sweep over all classes and regions
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic [63:0] d;
            case ($urandom_range(0, 6))
                0: a = LADDR;
                1: a = 32'h0000_0FFF;
                2: a = 32'h0000_1000;
                3: a = 32'h0000_3FFF;
                4: a = 32'h0000_4000;
                5: a = 32'h0000_0100;
                default: a = $urandom;
            endcase
            d = ($urandom_range(0, 2) == 0) ? KEY : {$urandom, $urandom};
            step("R10", ($urandom_range(0, 4) != 0), $urandom_range(0, 1),
                 ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0),
                 ($urandom_range(0, 4) == 0), a, d);
        end
        step("R10", 0, 0, 0, 0, 0, '0, '0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule